// File: doc/BRIEF.md
# Duty-Cycled Temperature Conversion Sequencer

This block decides when a temperature conversion chain (analog sense front end plus sigma-delta modulator and decimation filter) is powered, and which filter outputs become readings. A free-running period counter marks sample boundaries. In the low-power mode every boundary wakes the chain. The analog front end comes up first, the modulator one cycle later, and a programmable settling window then hides the modulator and filter start-up. The first filter output after that window is taken as the reading, and the chain powers straight back down. In the high-rate mode the chain wakes once and then stays on. From then on, the first filter output after each boundary becomes a reading, and a select output asks for the slower modulator clock used in this mode.

Each reading leaves on a valid/ready stream and is compared against a high and a low threshold. The flags are sticky: a clear request is honoured only once the latest reading has moved back past its threshold by a programmable hysteresis margin. The mode input is sampled only at a sample boundary, in the idle or continuous state. The analog core and the filter datapath are outside this block.

Top module: `temp_sample_seq`

## Requirements
- R1: After reset, ana_en, mod_en, mod_clk_low, rd_valid, hi_alert and lo_alert are all 0 and rd_data is 0.
- R2: A sample boundary occurs every period_cycles clocks, the first one period_cycles clocks after reset. When the chain is idle, a boundary raises ana_en on the next cycle. mod_en follows one cycle after ana_en and is never high without ana_en.
- R3: Filter strobes that arrive while the converter is settling are discarded. Settling lasts max(settle_cycles,1) cycles after mod_en rises, and the first reading is the filt_data present with the first filt_valid after that window.
- R4: In low-power mode (mode_fast=0) each wake-up captures exactly one reading, and both enables drop in the cycle the reading appears. With filt_valid held high, ana_en is high for exactly settle_cycles+2 cycles per period.
- R5: In high-rate mode (mode_fast=1), the enables stay high once the first reading is taken. After each later boundary, the first filt_valid is captured as the next reading.
- R6: mode_fast is acted on only at a boundary seen while idle or in continuous running. A change at any other time has no effect on the enables until such a boundary. On a boundary in continuous running with mode_fast=0, the chain powers down.
- R7: mod_clk_low is 1 exactly while the mode latched at the last acting boundary is high-rate.
- R8: rd_valid stays high until a cycle with rd_ready=1. If a new reading is captured while one is pending, the new data replaces it and rd_valid stays high.
- R9: hi_alert sets when a captured reading is >= hi_thresh. It then holds until alert_clr is seen while the previous reading plus hyst is below hi_thresh.
- R10: lo_alert sets when a captured reading is <= lo_thresh. It then holds until alert_clr is seen while the previous reading is above lo_thresh plus hyst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_fast | input | 1 | 1 = high-rate, 0 = low-power |
| period_cycles | input | PW | Clocks per sample period (>= 2) |
| settle_cycles | input | SW | Settling window in clocks |
| filt_valid | input | 1 | Filter output strobe |
| filt_data | input | DW | Filter output value |
| hi_thresh | input | DW | High alert threshold |
| lo_thresh | input | DW | Low alert threshold |
| hyst | input | DW | Alert clear margin |
| alert_clr | input | 1 | Request to clear both alerts |
| ana_en | output | 1 | Analog front-end enable |
| mod_en | output | 1 | Modulator enable |
| mod_clk_low | output | 1 | Slow modulator clock select |
| rd_valid | output | 1 | Reading valid |
| rd_ready | input | 1 | Reading accepted |
| rd_data | output | DW | Reading value |
| hi_alert | output | 1 | Sticky high-temperature flag |
| lo_alert | output | 1 | Sticky low-temperature flag |

## Verification
The low-power mode is tried with filter strobes held high, so that the enable duty cycle can be counted against settle_cycles+2. It is also tried with sparse strobes, which show that strobes inside the settling window are discarded and that capture waits for the next one. The high-rate mode is entered and left with mode changes placed mid-period and mid-wake-up, which separates boundary-only switching from immediate switching. A stalling ready pattern tells holding apart from overwriting. A data sweep across both thresholds, with clear pulses, shows set, sticky and hysteresis-gated clear behaviour.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_POWER_UP = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_CAPTURE  = 3'd3,
    ST_RUN      = 3'd4
  } seq_state_t;
endpackage

// File: rtl/tss_period_ctr.sv
module tss_period_ctr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;

  assign tick = (cnt == period - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/tss_alert_flag.sv
module tss_alert_flag #(
  parameter int DW        = 10,
  parameter bit HIGH_SIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] last,
  input  logic [DW-1:0] thr,
  input  logic [DW-1:0] hyst,
  input  logic          clr,
  output logic          flag
);
  localparam int XW = DW + 1;
  logic hit, clear_ok;

  generate
    if (HIGH_SIDE) begin : g_high
      assign hit      = (data >= thr);
      assign clear_ok = ({1'b0, last} + {1'b0, hyst}) < {1'b0, thr};
    end else begin : g_low
      assign hit      = (data <= thr);
      assign clear_ok = {1'b0, last} > ({1'b0, thr} + {1'b0, hyst});
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flag <= 1'b0;
    else if (cap && hit)    flag <= 1'b1;
    else if (clr && clear_ok) flag <= 1'b0;
  end

  logic [XW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/temp_sample_seq.sv
module temp_sample_seq
  import tss_pkg::*;
#(
  parameter int DW = 10,
  parameter int PW = 16,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_fast,
  input  logic [PW-1:0] period_cycles,
  input  logic [SW-1:0] settle_cycles,
  input  logic          filt_valid,
  input  logic [DW-1:0] filt_data,
  input  logic [DW-1:0] hi_thresh,
  input  logic [DW-1:0] lo_thresh,
  input  logic [DW-1:0] hyst,
  input  logic          alert_clr,
  output logic          ana_en,
  output logic          mod_en,
  output logic          mod_clk_low,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          hi_alert,
  output logic          lo_alert
);
  seq_state_t    state, state_nx;
  logic          tick;
  logic [SW-1:0] scnt;
  logic          amode;
  logic          cap;
  logic          settle_done;

  tss_period_ctr #(.PW(PW)) u_period (
    .clk(clk), .rst_n(rst_n), .period(period_cycles), .tick(tick)
  );

  assign settle_done = ({1'b0, scnt} + (SW+1)'(1)) >= {1'b0, settle_cycles};
  assign cap         = (state == ST_CAPTURE) && filt_valid;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OFF:      if (tick) state_nx = ST_POWER_UP;
      ST_POWER_UP: state_nx = ST_SETTLE;
      ST_SETTLE:   if (settle_done) state_nx = ST_CAPTURE;
      ST_CAPTURE:  if (filt_valid) state_nx = amode ? ST_RUN : ST_OFF;
      ST_RUN:      if (tick) state_nx = mode_fast ? ST_CAPTURE : ST_OFF;
      default:     state_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      scnt  <= '0;
      amode <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_POWER_UP)     scnt <= '0;
      else if (state == ST_SETTLE)  scnt <= scnt + SW'(1);
      if (tick && (state == ST_OFF || state == ST_RUN)) amode <= mode_fast;
    end
  end

  assign ana_en      = (state != ST_OFF);
  assign mod_en      = (state == ST_SETTLE) || (state == ST_CAPTURE) || (state == ST_RUN);
  assign mod_clk_low = amode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (cap) begin
      rd_valid <= 1'b1;
      rd_data  <= filt_data;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  tss_alert_flag #(.DW(DW), .HIGH_SIDE(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .cap(cap), .data(filt_data), .last(rd_data),
    .thr(hi_thresh), .hyst(hyst), .clr(alert_clr), .flag(hi_alert)
  );

  tss_alert_flag #(.DW(DW), .HIGH_SIDE(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .cap(cap), .data(filt_data), .last(rd_data),
    .thr(lo_thresh), .hyst(hyst), .clr(alert_clr), .flag(lo_alert)
  );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_fast,
  input logic          rd_ready,
  input logic          alert_clr,
  input logic          ana_en,
  input logic          mod_en,
  input logic          mod_clk_low,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          hi_alert,
  input logic          lo_alert
);
  // R2: modulator never runs without the analog front end
  p_mod_needs_ana_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> ana_en);

  // R2: front end comes up one cycle before the modulator
  p_ana_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ana_en) |-> !mod_en);

  // R4: a fresh low-power reading coincides with power-down
  p_slow_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_valid) && !mod_clk_low) |-> !ana_en);

  // R5: high-rate operation with high-rate request keeps the chain on
  p_fast_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_en && mod_clk_low && mode_fast) |=> ana_en);

  // R8: pending reading is held until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  // R9: high flag is sticky without a clear request
  p_hi_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_alert && !alert_clr) |=> hi_alert);

  // R10: low flag is sticky without a clear request
  p_lo_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_alert && !alert_clr) |=> lo_alert);

  logic [DW-1:0] unused_d;
  assign unused_d = rd_data;
endmodule

bind temp_sample_seq tss_checker #(.DW(DW)) u_tss_checker (
  .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .rd_ready(rd_ready),
  .alert_clr(alert_clr), .ana_en(ana_en), .mod_en(mod_en),
  .mod_clk_low(mod_clk_low), .rd_valid(rd_valid), .rd_data(rd_data),
  .hi_alert(hi_alert), .lo_alert(lo_alert)
);

// File: tb/test_temp_sample_seq.sv
module test_temp_sample_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int PW = 16;
  localparam int SW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_fast = 1'b0;
  logic [PW-1:0] period_cycles = PW'(60);
  logic [SW-1:0] settle_cycles = SW'(10);
  logic          filt_valid = 1'b0;
  logic [DW-1:0] filt_data = '0;
  logic [DW-1:0] hi_thresh = DW'(700);
  logic [DW-1:0] lo_thresh = DW'(100);
  logic [DW-1:0] hyst = DW'(20);
  logic          alert_clr = 1'b0;
  logic          rd_ready = 1'b1;
  logic          ana_en, mod_en, mod_clk_low, rd_valid, hi_alert, lo_alert;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_sample_seq #(.DW(DW), .PW(PW), .SW(SW)) i_temp_sample_seq (
    .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .period_cycles(period_cycles),
    .settle_cycles(settle_cycles), .filt_valid(filt_valid), .filt_data(filt_data),
    .hi_thresh(hi_thresh), .lo_thresh(lo_thresh), .hyst(hyst), .alert_clr(alert_clr),
    .ana_en(ana_en), .mod_en(mod_en), .mod_clk_low(mod_clk_low), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .hi_alert(hi_alert), .lo_alert(lo_alert)
  );

  // behavioural reference: phase 0 idle, 1 front end up, 2 settling, 3 waiting, 4 continuous
  int  m_pc = 0, m_ph = 0, m_sc = 0;
  bit  m_am = 0, m_rv = 0, m_hi = 0, m_lo = 0;
  int  m_rd = 0;
  int  m_caps = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit tk, cp;
      int st, nph;
      tk = (m_pc == int'(period_cycles) - 1);
      m_pc = tk ? 0 : m_pc + 1;
      st = (int'(settle_cycles) < 1) ? 1 : int'(settle_cycles);
      cp = (m_ph == 3) && filt_valid;
      nph = m_ph;
      case (m_ph)
        0: if (tk) begin m_am = mode_fast; nph = 1; end
        1: begin nph = 2; m_sc = 0; end
        2: begin if (m_sc + 1 >= st) nph = 3; m_sc = m_sc + 1; end
        3: if (filt_valid) nph = m_am ? 4 : 0;
        default: if (tk) begin m_am = mode_fast; nph = mode_fast ? 3 : 0; end
      endcase
      if (cp && int'(filt_data) >= int'(hi_thresh)) m_hi = 1;
      else if (alert_clr && (m_rd + int'(hyst) < int'(hi_thresh))) m_hi = 0;
      if (cp && int'(filt_data) <= int'(lo_thresh)) m_lo = 1;
      else if (alert_clr && (m_rd > int'(lo_thresh) + int'(hyst))) m_lo = 0;
      if (cp) begin m_rv = 1; m_rd = int'(filt_data); m_caps++; end
      else if (m_rv && rd_ready) m_rv = 0;
      m_ph = nph;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 R4 R5 R6 ana_en", int'(ana_en), int'(m_ph != 0));
      chk("R2 R3 mod_en", int'(mod_en), int'(m_ph >= 2));
      chk("R7 mod_clk_low", int'(mod_clk_low), int'(m_am));
      chk("R8 rd_valid", int'(rd_valid), int'(m_rv));
      chk("R3 R4 R5 rd_data", int'(rd_data), m_rd);
      chk("R9 hi_alert", int'(hi_alert), int'(m_hi));
      chk("R10 lo_alert", int'(lo_alert), int'(m_lo));
    end
  end

  int cyc = 0;
  always @(negedge clk) cyc++;

  task automatic step(input int n, input int fv_mod);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      filt_data  <= DW'((cyc * 37 + 11) % 1024);
      filt_valid <= (fv_mod <= 1) ? 1'b1 : ((cyc % fv_mod) == 0);
      rd_ready   <= ((cyc % 7) != 3) && ((cyc % 13) != 5);
      alert_clr  <= ((cyc % 53) == 0);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int hi_cnt, rises, caps0;
    bit prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ana_en", int'(ana_en), 0);
    chk("R1 mod_en", int'(mod_en), 0);
    chk("R1 mod_clk_low", int'(mod_clk_low), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 alerts", int'(hi_alert) + int'(lo_alert), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // R4 duty cycle in low-power mode with strobes held high
    hi_cnt = 0; rises = 0; prev = 0; caps0 = m_caps;
    for (int i = 0; i < 170; i++) begin
      step(1, 1);
      if (ana_en) hi_cnt++;
      if (ana_en && !prev) rises++;
      prev = ana_en;
    end
    chk("R4 wake-ups", rises, 2);
    chk("R4 on cycles", hi_cnt, 2 * (int'(settle_cycles) + 2));
    chk("R4 one reading per wake-up", m_caps - caps0, 2);

    // R3 sparse strobes: settling strobes dropped
    step(400, 5);

    // R6 request high-rate mid-period, R5 continuous running
    period_cycles = PW'(40);
    step(17, 4);
    mode_fast = 1'b1;
    step(150, 3);
    hi_cnt = 0;
    for (int i = 0; i < 100; i++) begin
      step(1, 6);
      if (ana_en) hi_cnt++;
    end
    chk("R5 continuous on", hi_cnt, 100);

    // R6 back to low-power mid-period, then a toggle during a wake-up
    step(9, 3);
    mode_fast = 1'b0;
    step(200, 3);
    settle_cycles = SW'(0);
    step(50, 2);
    mode_fast = 1'b1;
    step(3, 2);
    mode_fast = 1'b0;
    step(250, 2);

    // R9 R10 hysteresis with a wide margin
    hyst = DW'(300);
    step(400, 1);
    cmp_on = 0;
    @(negedge clk);
    finish_run();
  end
endmodule